// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block collects eleven level-sensitive interrupt lines coming from a peripheral bus bridge and turns them into message writes towards a host. Each line is synchronised, watched for a low-to-high change, and, when that line is enabled, causes one write of a programmed data word to a programmed address on a single-beat valid/ready write port. Software sees the lines through a small register file: an enable mask, a request latch that clears when read, a pending latch that also clears when read, and a live level view whose reads have no effect.

Because a message fires only on a change, a line that is already high when it is enabled produces nothing by itself. Software can compare the level view against its enable mask and, through a write-only trigger register, force a message to replay a line that is still held. While a message waits for acceptance, further causes fold into a single follow-up message.

Top module: `irq_msg_aggregator`

## Requirements
- R1: A change on `irq_in` shows in the level register (offset 0x28, bit i = line i, all eleven bits) after exactly two rising clock edges.
- R2: Only lines in the implemented set 0x5FF (bits 0-8 and 10) can set request or pending bits or cause a message; a change on line 9 is visible only in the level register.
- R3: Reading the request register (offset 0x0C) returns the latched enabled rising edges and clears them in that access; an edge latched in the same cycle as the read survives into the next read.
- R4: Reads of the level register return the synchronised input state and change no register.
- R5: The pending register (offset 0x1C) latches a rising edge of every implemented line whatever the mask, clears when read, and the read leaves the level register unchanged.
- R6: A message is requested only by a rising edge on an enabled implemented line or by a trigger write; enabling a line that is already high requests none.
- R7: The target register (offset 0x04) holds one 32-bit word; a message carries `msg_addr` = the word with its low 5 bits cleared and `msg_data` = the low 5 bits of the word, taken when the message is raised.
- R8: The mask register (offset 0x18) resets to zero; a write stores bit i = 1 to enable line i, keeping only implemented bits, and reads back the stored value. All registers reset to zero.
- R9: `msg_valid` stays high with unchanged address and data until `msg_ready`; any number of causes while a message waits yield exactly one further message.
- R10: A write of any value to the trigger register (offset 0x30) requests a message regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 11 | Raw level-sensitive interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of `reg_rd` |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Host accepts the message |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
Single isolated edges on enabled lines check that one change gives one message with the programmed address and data, while edges under a stalled `msg_ready` separate correct merging from dropped or duplicated messages. Edges on a masked line and on the unimplemented line 9, followed by unmasking a held line, tell apart the request, pending and level views and show that enabling alone is silent. Reads racing fresh edges and a long pseudo-random phase of toggling lines, stalls, reads and writes compare every cycle against a behavioural reference.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam logic [7:0] OFS_TARGET  = 8'h04;
    localparam logic [7:0] OFS_REQUEST = 8'h0C;
    localparam logic [7:0] OFS_MASK    = 8'h18;
    localparam logic [7:0] OFS_PENDING = 8'h1C;
    localparam logic [7:0] OFS_LEVEL   = 8'h28;
    localparam logic [7:0] OFS_TRIGGER = 8'h30;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign rise  = st_q.s2 & ~st_q.prev;

    // R1: level follows the first stage one edge later
    p_two_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level == $past(st_q.s1) || $past(!rst_n));
endmodule

// File: rtl/irq_msg_issuer.sv
module irq_msg_issuer #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [WORD_W-1:0] target,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    localparam int unsigned HI_W = WORD_W - DATA_W;

    typedef struct packed {
        logic              valid;
        logic              owed;
        logic [WORD_W-1:0] word;
    } iss_t;

    iss_t st_d, st_q;
    logic busy;

    always_comb begin
        st_d = st_q;
        busy = st_q.valid & ~msg_ready;
        if (busy) begin
            st_d.valid = 1'b1;
            st_d.owed  = st_q.owed | fire;
        end else begin
            st_d.valid = st_q.owed | fire;
            st_d.owed  = 1'b0;
            if (st_d.valid) st_d.word = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_valid = st_q.valid;
    assign msg_addr  = {st_q.word[WORD_W-1:DATA_W], {DATA_W{1'b0}}};
    assign msg_data  = {{HI_W{1'b0}}, st_q.word[DATA_W-1:0]};

    // R9: a waiting message holds its contents
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
    // R9: a follow-up is only owed behind a live message
    p_owed_behind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.owed |-> msg_valid);
    // R6: no cause, no message
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && !st_q.owed && !fire |=> !msg_valid);
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned  NUM_IN    = 11,
    parameter logic [10:0]  IMPL_MASK = 11'h5FF,
    parameter int unsigned  WORD_W    = 32,
    parameter int unsigned  DATA_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    localparam int unsigned PAD_W = WORD_W - NUM_IN;
    localparam logic [NUM_IN-1:0] IMPL = NUM_IN'(IMPL_MASK);

    typedef struct packed {
        logic [WORD_W-1:0] target;
        logic [NUM_IN-1:0] req;
        logic [NUM_IN-1:0] pend;
        logic [NUM_IN-1:0] mask;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [NUM_IN-1:0] level, rise, qual, en_rise;
    logic fire, rd_req, rd_pend;

    irq_sync_edge #(.N(NUM_IN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (irq_in),
        .level (level),
        .rise  (rise)
    );

    always_comb begin
        rg_d    = rg_q;
        qual    = rise & IMPL;
        en_rise = qual & rg_q.mask;
        rd_req  = reg_rd && (reg_addr == OFS_REQUEST);
        rd_pend = reg_rd && (reg_addr == OFS_PENDING);
        rg_d.req  = (rd_req  ? '0 : rg_q.req)  | en_rise;
        rg_d.pend = (rd_pend ? '0 : rg_q.pend) | qual;
        if (reg_wr && reg_addr == OFS_MASK)   rg_d.mask   = reg_wdata[NUM_IN-1:0] & IMPL;
        if (reg_wr && reg_addr == OFS_TARGET) rg_d.target = reg_wdata;
        fire = (|en_rise) | (reg_wr && reg_addr == OFS_TRIGGER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (reg_addr)
            OFS_TARGET:  reg_rdata = rg_q.target;
            OFS_REQUEST: reg_rdata = {{PAD_W{1'b0}}, rg_q.req};
            OFS_MASK:    reg_rdata = {{PAD_W{1'b0}}, rg_q.mask};
            OFS_PENDING: reg_rdata = {{PAD_W{1'b0}}, rg_q.pend};
            OFS_LEVEL:   reg_rdata = {{PAD_W{1'b0}}, level};
            default:     reg_rdata = '0;
        endcase
    end

    irq_msg_issuer #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .target    (rg_q.target),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    // R2: unimplemented lines never reach the latches
    p_impl_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rg_q.req | rg_q.pend | rg_q.mask) & ~IMPL) == '0);
    // R3: after a request read only same-cycle edges remain
    p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rg_q.req & ~$past(en_rise)) == '0);
    // R5: after a pending read only same-cycle edges remain
    p_pend_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |=> (rg_q.pend & ~$past(qual)) == '0);
    // R6: newly set request bits belong to enabled lines
    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rg_q.req & ~$past(rg_q.req)) & ~$past(rg_q.mask)) == '0);
endmodule

// File: tb/irq_msg_aggregator_tb.sv
module irq_msg_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq = '0;
    logic        wr = 1'b0, rd = 1'b0, ready = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, maddr, mdata;
    logic        mvalid;

    int checks = 0, fails = 0, dut_msgs = 0;
    logic [31:0] last_addr = '0, last_data = '0;

    // reference model state
    logic [10:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_req = '0, m_pend = '0, m_mask = '0;
    logic [31:0] m_target = '0, m_word = '0;
    logic        m_valid = 1'b0, m_owed = 1'b0;

    always #2 clk = ~clk;

    irq_msg_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_wr(wr), .reg_rd(rd),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .msg_valid(mvalid), .msg_ready(ready), .msg_addr(maddr), .msg_data(mdata)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_req = '0; m_pend = '0; m_mask = '0;
            m_target = '0; m_word = '0; m_valid = 1'b0; m_owed = 1'b0;
        end else begin
            automatic logic [10:0] edges = m_s2 & ~m_prev & 11'h5FF;
            automatic logic [10:0] en = edges & m_mask;
            automatic bit cause = (en != 0) || (wr && addr == 8'h30);
            automatic logic [31:0] old_target = m_target;
            m_req  = ((rd && addr == 8'h0C) ? 11'h0 : m_req) | en;
            m_pend = ((rd && addr == 8'h1C) ? 11'h0 : m_pend) | edges;
            if (wr && addr == 8'h18) m_mask = wdata[10:0] & 11'h5FF;
            if (wr && addr == 8'h04) m_target = wdata;
            if (m_valid && !ready) begin
                m_owed = m_owed || cause;
            end else begin
                m_valid = m_owed || cause;
                m_owed = 1'b0;
                if (m_valid) m_word = old_target;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
        end
    end

    always @(negedge clk) begin
        check("R9 msg_valid", {31'b0, mvalid}, {31'b0, m_valid});
        if (m_valid) begin
            check("R7 msg_addr", maddr, {m_word[31:5], 5'b0});
            check("R7 msg_data", mdata, {27'b0, m_word[4:0]});
        end
        if (mvalid && ready) begin
            dut_msgs++; last_addr = maddr; last_data = mdata;
        end
        if (rd && rst_n) begin
            case (addr)
                8'h04: check("R7 target read", rdata, m_target);
                8'h0C: check("R3 request read", rdata, {21'b0, m_req});
                8'h18: check("R8 mask read", rdata, {21'b0, m_mask});
                8'h1C: check("R5 pending read", rdata, {21'b0, m_pend});
                8'h28: check("R4 level read", rdata, {21'b0, m_s2});
                default: check("R4 unmapped read", rdata, 32'h0);
            endcase
        end
    end

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; wr = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1; rd = 1'b1; addr = a;
        @(negedge clk); d = rdata;
        @(posedge clk); #1; rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        idle(4); rst_n = 1'b1; idle(2);
        // reset state, R8
        rd_reg(8'h18, v); check("R8 reset mask", v, 0);
        rd_reg(8'h04, v); check("R8 reset target", v, 0);
        check("R8 reset msg_valid", {31'b0, mvalid}, 0);
        wr_reg(8'h04, 32'h8000_0013);
        wr_reg(8'h18, 32'h0000_07FF);
        rd_reg(8'h18, v); check("R8 mask keeps implemented bits", v, 32'h5FF);
        // R6 single enabled edge
        irq[0] = 1'b1; idle(6);
        check("R6 one message per edge", dut_msgs, 1);
        check("R7 first addr", last_addr, 32'h8000_0000);
        check("R7 first data", last_data, 32'h13);
        rd_reg(8'h0C, v); check("R3 request latched", v, 32'h001);
        rd_reg(8'h0C, v); check("R3 request cleared by read", v, 32'h0);
        // R9 merging under stall
        ready = 1'b0;
        irq[1] = 1'b1; idle(6);
        irq[2] = 1'b1; idle(6);
        wr_reg(8'h30, 32'h0); idle(4);
        check("R9 stalled no completion", dut_msgs, 1);
        ready = 1'b1; idle(4);
        check("R9 one message plus one merged", dut_msgs, 3);
        // R2 unimplemented line 9
        irq[9] = 1'b1; idle(6);
        check("R2 line 9 sends nothing", dut_msgs, 3);
        rd_reg(8'h0C, v); check("R2 request excludes line 9", v, 32'h006);
        rd_reg(8'h28, v); check("R4 level shows all lines", v, 32'h207);
        rd_reg(8'h1C, v); check("R5 pending latched", v, 32'h007);
        rd_reg(8'h1C, v); check("R5 pending cleared", v, 32'h0);
        rd_reg(8'h28, v); check("R5 level kept after pending read", v, 32'h207);
        // R8 masked line, then R6 unmask while held
        wr_reg(8'h18, 32'h0000_05F7);
        irq[3] = 1'b1; idle(6);
        check("R8 masked line silent", dut_msgs, 3);
        rd_reg(8'h1C, v); check("R5 pending ignores mask", v, 32'h008);
        rd_reg(8'h0C, v); check("R6 masked edge not requested", v, 32'h0);
        wr_reg(8'h18, 32'h0000_05FF); idle(6);
        check("R6 unmask held line silent", dut_msgs, 3);
        // R10 trigger
        wr_reg(8'h30, 32'hDEAD_BEEF); idle(4);
        check("R10 trigger sends message", dut_msgs, 4);
        // R6 re-edge
        irq[0] = 1'b0; idle(4); irq[0] = 1'b1; idle(6);
        check("R6 re-raised line sends again", dut_msgs, 5);
        // R7 new target
        wr_reg(8'h04, 32'h1234_5678);
        wr_reg(8'h30, 32'h0); idle(4);
        check("R7 new addr", last_addr, 32'h1234_5660);
        check("R7 new data", last_data, 32'h18);
        // R1 two-edge latency
        irq = '0; idle(6);
        irq[4] = 1'b1;
        rd_reg(8'h28, v); check("R1 level after one edge", v, 32'h0);
        check("R1 level after two edges", rdata, 32'h010);
        idle(2); rd_reg(8'h28, v); check("R1 level settled", v, 32'h010);
        // random phase compared against the model every cycle
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(posedge clk); #1;
            if (lfsr[3:1] == 3'd0) irq = lfsr[26:16];
            ready = lfsr[5] | lfsr[6];
            wr = 1'b0; rd = 1'b0;
            case (lfsr[10:8])
                3'd0: begin rd = 1'b1; addr = 8'h0C; end
                3'd1: begin rd = 1'b1; addr = 8'h1C; end
                3'd2: begin rd = 1'b1; addr = 8'h28; end
                3'd3: begin wr = lfsr[11] & lfsr[12]; addr = 8'h30; wdata = lfsr; end
                3'd4: begin wr = lfsr[13] & lfsr[14] & lfsr[15]; addr = 8'h18; wdata = lfsr; end
                default: ;
            endcase
        end
        @(posedge clk); #1; wr = 1'b0; rd = 1'b0; ready = 1'b1;
        idle(8);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule